// File: doc/BRIEF.md
# Chained-Buffer Peripheral DMA Channel Pair

This block moves data for one serial peripheral between memory and that peripheral's holding registers. It has one receive direction and one transmit direction. Each direction keeps a current buffer descriptor (address and remaining count) and a queued descriptor. When the current buffer runs out, the queued descriptor is promoted automatically, so a stream can continue without a gap while software refills the queue.

Software programs the descriptors, enables the directions and reads progress back through a simple register bus. Receive units are taken from the peripheral when it signals ready and are written to memory. Transmit units are read from memory and handed to the peripheral when it signals ready. Both directions share one memory port, which asks a bus arbiter for access with a request/grant handshake. Four sticky flags report buffer completion, and the peripheral can turn them into interrupts.

Top module: `chain_dma_pair`

## Requirements
- R1: After reset, every readable register reads zero, all four completion flags are low, and no memory request is raised.
- R2: The registers sit at these byte addresses: 0x100 receive address, 0x104 receive count, 0x108 transmit address, 0x10C transmit count, 0x110 receive queued address, 0x114 receive queued count, 0x118 transmit queued address, 0x11C transmit queued count, 0x120 control (write-only, reads zero), 0x124 status (read-only). Address registers are 32 bits wide. Count registers are 16 bits wide and read with zero upper bits. Read data appears on `reg_rdata` in the cycle after `reg_rd`.
- R3: In a control write, bit 0 enables receive, bit 1 disables receive, bit 8 enables transmit and bit 9 disables transmit. When enable and disable are written together, disable wins. Status bit 0 shows receive enabled and status bit 8 shows transmit enabled.
- R4: Each completed unit decrements the count by one. It also advances the address by 1, 2 or 4 when `size_sel` is 0, 1 or 2 respectively (a value of 3 advances by 4).
- R5: When a unit brings the count to zero and the queued count is nonzero, the queued address and count become current and the queued count becomes zero.
- R6: When a unit brings the count to zero and the queued count is zero, that direction issues no more transfers.
- R7: When a direction's count reaches zero through a transfer, its end flag (`rx_end`/`tx_end`) sets. If no queued buffer remains at that point, its both-done flag (`rx_both_done`/`tx_both_done`) also sets.
- R8: Writing either count register of a direction clears both of that direction's flags.
- R9: Writing the queued count of an enabled direction whose count is zero immediately loads the queued address and the written count into the current registers, and leaves the queued count at zero.
- R10: A receive unit pulses `rx_take` for one cycle and captures `rx_data`. It then holds a write request (`mem_req`=1, `mem_we`=1) at the current receive address with that data until `mem_gnt` is seen.
- R11: A transmit unit holds a read request (`mem_req`=1, `mem_we`=0) at the current transmit address until granted. In the following cycle it presents the granted `mem_rdata` on `tx_data` with a one-cycle `tx_load` pulse.
- R12: When both directions are ready at the same time, the receive unit is started first.
- R13: A disabled direction transfers nothing and its registers stay unchanged, even while its peripheral signals ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| size_sel | input | 2 | Unit size: 0 byte, 1 halfword, 2 word |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 9 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, registered |
| rx_ready | input | 1 | Peripheral has a received unit |
| rx_data | input | 32 | Peripheral receive holding register |
| rx_take | output | 1 | Receive holding register consumed |
| tx_ready | input | 1 | Peripheral can accept a unit |
| tx_data | output | 32 | Data for the transmit holding register |
| tx_load | output | 1 | Load strobe for tx_data |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 write, 0 read |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_gnt | input | 1 | Access granted and completed this cycle |
| mem_rdata | input | 32 | Memory read data, valid with mem_gnt |
| rx_end | output | 1 | Receive current buffer finished |
| rx_both_done | output | 1 | Receive buffers all exhausted |
| tx_end | output | 1 | Transmit current buffer finished |
| tx_both_done | output | 1 | Transmit buffers all exhausted |

## Verification
The assertions assume that `mem_gnt` arrives only while `mem_req` is high, and that the peripheral lowers `rx_ready` once it sees `rx_take` unless it has another unit waiting. They also assume that `size_sel` does not change while a direction is moving data, and that software does not rewrite a direction's count in the same cycle a unit completes. The bench memory model grants only pending requests and can add a set number of wait cycles. Its peripheral model counts pending receive units down on each `rx_take`. `size_sel` is changed only while both directions are idle, and count writes are made only while the direction is stopped or drained.

// File: rtl/cdma_pkg.sv
package cdma_pkg;
  localparam int REG_W  = 32;
  localparam int ADDR_W = 9;

  localparam logic [ADDR_W-1:0] A_RX_PTR   = 9'h100;
  localparam logic [ADDR_W-1:0] A_RX_CNT   = 9'h104;
  localparam logic [ADDR_W-1:0] A_TX_PTR   = 9'h108;
  localparam logic [ADDR_W-1:0] A_TX_CNT   = 9'h10C;
  localparam logic [ADDR_W-1:0] A_RX_NPTR  = 9'h110;
  localparam logic [ADDR_W-1:0] A_RX_NCNT  = 9'h114;
  localparam logic [ADDR_W-1:0] A_TX_NPTR  = 9'h118;
  localparam logic [ADDR_W-1:0] A_TX_NCNT  = 9'h11C;
  localparam logic [ADDR_W-1:0] A_CTRL     = 9'h120;
  localparam logic [ADDR_W-1:0] A_STAT     = 9'h124;

  localparam int B_RX_ON  = 0;
  localparam int B_RX_OFF = 1;
  localparam int B_TX_ON  = 8;
  localparam int B_TX_OFF = 9;

  typedef enum logic [1:0] {ENG_IDLE, ENG_RX, ENG_TX} eng_state_t;

  function automatic logic [2:0] unit_step(input logic [1:0] sz);
    case (sz)
      2'd0:    unit_step = 3'd1;
      2'd1:    unit_step = 3'd2;
      default: unit_step = 3'd4;
    endcase
  endfunction
endpackage

// File: rtl/cdma_desc.sv
module cdma_desc #(
  parameter int PTR_W = 32,
  parameter int CNT_W = 16,
  parameter int W     = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             adv,
  input  logic [2:0]       step,
  input  logic             wr_ptr,
  input  logic             wr_cnt,
  input  logic             wr_nptr,
  input  logic             wr_ncnt,
  input  logic [W-1:0]     wdata,
  output logic [PTR_W-1:0] ptr,
  output logic [CNT_W-1:0] cnt,
  output logic [PTR_W-1:0] nptr,
  output logic [CNT_W-1:0] ncnt,
  output logic             end_flag,
  output logic             all_flag
);
  logic [PTR_W-1:0] p_n, np_n;
  logic [CNT_W-1:0] c_n, nc_n;
  logic             e_n, b_n;

  always_comb begin
    p_n = ptr; c_n = cnt; np_n = nptr; nc_n = ncnt;
    e_n = end_flag; b_n = all_flag;
    if (adv) begin
      p_n = ptr + PTR_W'(step);
      c_n = cnt - CNT_W'(1);
      if (cnt == CNT_W'(1)) begin
        e_n = 1'b1;
        if (ncnt != '0) begin
          p_n  = nptr;
          c_n  = ncnt;
          nc_n = '0;
        end else begin
          b_n = 1'b1;
        end
      end
    end
    if (wr_ptr)  p_n  = wdata[PTR_W-1:0];
    if (wr_nptr) np_n = wdata[PTR_W-1:0];
    if (wr_cnt) begin
      c_n = wdata[CNT_W-1:0];
      e_n = 1'b0;
      b_n = 1'b0;
    end
    if (wr_ncnt) begin
      e_n = 1'b0;
      b_n = 1'b0;
      if (en && c_n == '0) begin
        p_n  = np_n;
        c_n  = wdata[CNT_W-1:0];
        nc_n = '0;
      end else begin
        nc_n = wdata[CNT_W-1:0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr <= '0; cnt <= '0; nptr <= '0; ncnt <= '0;
      end_flag <= 1'b0; all_flag <= 1'b0;
    end else begin
      ptr <= p_n; cnt <= c_n; nptr <= np_n; ncnt <= nc_n;
      end_flag <= e_n; all_flag <= b_n;
    end
  end

  logic any_wr;
  assign any_wr = wr_ptr | wr_cnt | wr_nptr | wr_ncnt;

  p_cnt_dec_r4: assert property (@(posedge clk) disable iff (rst)
    (adv && !any_wr && cnt > CNT_W'(1)) |=>
      (cnt == $past(cnt) - CNT_W'(1) && ptr == $past(ptr) + PTR_W'($past(step))));

  p_chain_r5: assert property (@(posedge clk) disable iff (rst)
    (adv && !any_wr && cnt == CNT_W'(1) && ncnt != '0) |=>
      (cnt == $past(ncnt) && ptr == $past(nptr) && ncnt == '0 && end_flag));

  p_stop_r6: assert property (@(posedge clk) disable iff (rst)
    (adv && !any_wr && cnt == CNT_W'(1) && ncnt == '0) |=>
      (cnt == '0 && all_flag && end_flag));

  p_flag_clr_r8: assert property (@(posedge clk) disable iff (rst)
    (wr_cnt || wr_ncnt) |=> (!end_flag && !all_flag));

  p_no_adv_idle_r13: assert property (@(posedge clk) disable iff (rst)
    adv |-> cnt != '0);
endmodule

// File: rtl/cdma_engine.sv
module cdma_engine
  import cdma_pkg::*;
#(
  parameter int PTR_W  = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_act,
  input  logic              tx_act,
  input  logic              rx_ready,
  input  logic              tx_ready,
  input  logic [DATA_W-1:0] rx_data,
  input  logic [PTR_W-1:0]  rx_ptr,
  input  logic [PTR_W-1:0]  tx_ptr,
  input  logic              mem_gnt,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [PTR_W-1:0]  mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              rx_take,
  output logic              tx_load,
  output logic [DATA_W-1:0] tx_data,
  output logic              rx_adv,
  output logic              tx_adv
);
  eng_state_t state;

  assign rx_adv = (state == ENG_RX) && mem_gnt;
  assign tx_adv = (state == ENG_TX) && mem_gnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ENG_IDLE;
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      rx_take   <= 1'b0;
      tx_load   <= 1'b0;
      tx_data   <= '0;
    end else begin
      rx_take <= 1'b0;
      tx_load <= 1'b0;
      case (state)
        ENG_IDLE: begin
          if (rx_act && rx_ready) begin
            rx_take   <= 1'b1;
            mem_wdata <= rx_data;
            mem_addr  <= rx_ptr;
            mem_we    <= 1'b1;
            mem_req   <= 1'b1;
            state     <= ENG_RX;
          end else if (tx_act && tx_ready) begin
            mem_addr <= tx_ptr;
            mem_we   <= 1'b0;
            mem_req  <= 1'b1;
            state    <= ENG_TX;
          end
        end
        ENG_RX: begin
          if (mem_gnt) begin
            mem_req <= 1'b0;
            state   <= ENG_IDLE;
          end
        end
        ENG_TX: begin
          if (mem_gnt) begin
            mem_req <= 1'b0;
            tx_data <= mem_rdata;
            tx_load <= 1'b1;
            state   <= ENG_IDLE;
          end
        end
        default: state <= ENG_IDLE;
      endcase
    end
  end

  p_req_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  p_take_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    rx_take |=> !rx_take);

  p_tx_load_r11: assert property (@(posedge clk) disable iff (rst)
    tx_adv |=> (tx_load && !mem_req));

  p_rx_first_r12: assert property (@(posedge clk) disable iff (rst)
    (state == ENG_IDLE && rx_act && rx_ready) |=> (mem_req && mem_we));
endmodule

// File: rtl/chain_dma_pair.sv
module chain_dma_pair
  import cdma_pkg::*;
#(
  parameter int PTR_W  = 32,
  parameter int CNT_W  = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        size_sel,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic              rx_ready,
  input  logic [DATA_W-1:0] rx_data,
  output logic              rx_take,
  input  logic              tx_ready,
  output logic [DATA_W-1:0] tx_data,
  output logic              tx_load,
  output logic              mem_req,
  output logic              mem_we,
  output logic [PTR_W-1:0]  mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_gnt,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              rx_end,
  output logic              rx_both_done,
  output logic              tx_end,
  output logic              tx_both_done
);
  localparam int CNT_PAD = REG_W - CNT_W;
  localparam int PTR_PAD = REG_W - PTR_W;

  logic rx_en, tx_en;
  logic ctrl_wr;
  logic [2:0] step;
  logic rx_adv, tx_adv;
  logic [PTR_W-1:0] rx_ptr, rx_nptr, tx_ptr, tx_nptr;
  logic [CNT_W-1:0] rx_cnt, rx_ncnt, tx_cnt, tx_ncnt;

  assign step    = unit_step(size_sel);
  assign ctrl_wr = reg_wr && reg_addr == A_CTRL;

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_en <= 1'b0;
      tx_en <= 1'b0;
    end else if (ctrl_wr) begin
      if (reg_wdata[B_RX_OFF])     rx_en <= 1'b0;
      else if (reg_wdata[B_RX_ON]) rx_en <= 1'b1;
      if (reg_wdata[B_TX_OFF])     tx_en <= 1'b0;
      else if (reg_wdata[B_TX_ON]) tx_en <= 1'b1;
    end
  end

  cdma_desc #(.PTR_W(PTR_W), .CNT_W(CNT_W), .W(REG_W)) rx_desc_i (
    .clk(clk), .rst(rst), .en(rx_en), .adv(rx_adv), .step(step),
    .wr_ptr (reg_wr && reg_addr == A_RX_PTR),
    .wr_cnt (reg_wr && reg_addr == A_RX_CNT),
    .wr_nptr(reg_wr && reg_addr == A_RX_NPTR),
    .wr_ncnt(reg_wr && reg_addr == A_RX_NCNT),
    .wdata(reg_wdata), .ptr(rx_ptr), .cnt(rx_cnt), .nptr(rx_nptr), .ncnt(rx_ncnt),
    .end_flag(rx_end), .all_flag(rx_both_done)
  );

  cdma_desc #(.PTR_W(PTR_W), .CNT_W(CNT_W), .W(REG_W)) tx_desc_i (
    .clk(clk), .rst(rst), .en(tx_en), .adv(tx_adv), .step(step),
    .wr_ptr (reg_wr && reg_addr == A_TX_PTR),
    .wr_cnt (reg_wr && reg_addr == A_TX_CNT),
    .wr_nptr(reg_wr && reg_addr == A_TX_NPTR),
    .wr_ncnt(reg_wr && reg_addr == A_TX_NCNT),
    .wdata(reg_wdata), .ptr(tx_ptr), .cnt(tx_cnt), .nptr(tx_nptr), .ncnt(tx_ncnt),
    .end_flag(tx_end), .all_flag(tx_both_done)
  );

  cdma_engine #(.PTR_W(PTR_W), .DATA_W(DATA_W)) eng_i (
    .clk(clk), .rst(rst),
    .rx_act(rx_en && rx_cnt != '0), .tx_act(tx_en && tx_cnt != '0),
    .rx_ready(rx_ready), .tx_ready(tx_ready), .rx_data(rx_data),
    .rx_ptr(rx_ptr), .tx_ptr(tx_ptr), .mem_gnt(mem_gnt), .mem_rdata(mem_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .rx_take(rx_take), .tx_load(tx_load), .tx_data(tx_data),
    .rx_adv(rx_adv), .tx_adv(tx_adv)
  );

  logic [REG_W-1:0] rd_mux;
  always_comb begin
    case (reg_addr)
      A_RX_PTR:  rd_mux = {{PTR_PAD{1'b0}}, rx_ptr};
      A_RX_CNT:  rd_mux = {{CNT_PAD{1'b0}}, rx_cnt};
      A_TX_PTR:  rd_mux = {{PTR_PAD{1'b0}}, tx_ptr};
      A_TX_CNT:  rd_mux = {{CNT_PAD{1'b0}}, tx_cnt};
      A_RX_NPTR: rd_mux = {{PTR_PAD{1'b0}}, rx_nptr};
      A_RX_NCNT: rd_mux = {{CNT_PAD{1'b0}}, rx_ncnt};
      A_TX_NPTR: rd_mux = {{PTR_PAD{1'b0}}, tx_nptr};
      A_TX_NCNT: rd_mux = {{CNT_PAD{1'b0}}, tx_ncnt};
      A_STAT: begin
        rd_mux = '0;
        rd_mux[B_RX_ON] = rx_en;
        rd_mux[B_TX_ON] = tx_en;
      end
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_mux;
  end

  p_dis_wins_r3: assert property (@(posedge clk) disable iff (rst)
    (ctrl_wr && reg_wdata[B_RX_OFF]) |=> !rx_en);

  p_tx_dis_r3: assert property (@(posedge clk) disable iff (rst)
    (ctrl_wr && reg_wdata[B_TX_OFF]) |=> !tx_en);

  p_idle_quiet_r13: assert property (@(posedge clk) disable iff (rst)
    (!rx_en && !tx_en && !mem_req) |=> !mem_req);
endmodule

// File: tb/chain_dma_pair_tb_top.sv
module chain_dma_pair_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic [1:0]  size_sel = 2'd0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [8:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        rx_ready, rx_take, tx_ready = 1'b0, tx_load;
  logic [31:0] rx_data, tx_data;
  logic        mem_req, mem_we, mem_gnt = 1'b0;
  logic [31:0] mem_addr, mem_wdata, mem_rdata = '0;
  logic        rx_end, rx_both_done, tx_end, tx_both_done;

  chain_dma_pair dut_i (
    .clk(clk), .rst(rst), .size_sel(size_sel),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .rx_ready(rx_ready), .rx_data(rx_data), .rx_take(rx_take),
    .tx_ready(tx_ready), .tx_data(tx_data), .tx_load(tx_load),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_gnt(mem_gnt), .mem_rdata(mem_rdata),
    .rx_end(rx_end), .rx_both_done(rx_both_done),
    .tx_end(tx_end), .tx_both_done(tx_both_done)
  );

  int n_tests = 0, n_fail = 0;
  bit done = 0;

  // peripheral and memory models
  int rx_pending = 0, rx_seen = 0, gnt_dly = 0, wcnt = 0;
  logic [31:0] rx_base = 32'h0;
  int n_log = 0, n_tx = 0;
  logic [31:0] log_addr [16];
  logic [31:0] log_data [16];
  logic        log_we   [16];
  logic [31:0] tx_log   [16];

  assign rx_ready = (rx_pending != 0);
  assign rx_data  = rx_base + 32'(rx_seen);

  function automatic logic [31:0] mem_val(input logic [31:0] a);
    return a ^ 32'hA5A5_0000;
  endfunction

  always @(negedge clk) begin
    if (rx_take) begin
      rx_pending = rx_pending - 1;
      rx_seen    = rx_seen + 1;
    end
    if (tx_load && n_tx < 16) begin
      tx_log[n_tx] = tx_data;
      n_tx = n_tx + 1;
    end
    if (mem_req && !mem_gnt) begin
      if (wcnt >= gnt_dly) begin
        mem_gnt   = 1'b1;
        mem_rdata = mem_val(mem_addr);
        wcnt      = 0;
        if (n_log < 16) begin
          log_addr[n_log] = mem_addr;
          log_data[n_log] = mem_wdata;
          log_we[n_log]   = mem_we;
          n_log = n_log + 1;
        end
      end else begin
        wcnt = wcnt + 1;
      end
    end else begin
      mem_gnt = 1'b0;
    end
  end

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [8:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [8:0] a, input logic [31:0] exp);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a;
    @(negedge clk); reg_rd = 1'b0;
    chk(tag, reg_rdata, exp);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // register table: address, written value, expected read-back (R2)
  localparam logic [72:0] VEC [0:7] = '{
    {9'h100, 32'h1234_5678, 32'h1234_5678},
    {9'h104, 32'hABCD_1234, 32'h0000_1234},
    {9'h108, 32'h0000_0F00, 32'h0000_0F00},
    {9'h10C, 32'hFFFF_FFFF, 32'h0000_FFFF},
    {9'h110, 32'hDEAD_BEEF, 32'hDEAD_BEEF},
    {9'h114, 32'h0001_0002, 32'h0000_0002},
    {9'h118, 32'h8000_0001, 32'h8000_0001},
    {9'h11C, 32'h0000_7777, 32'h0000_7777}
  };

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk("R1 flags", {28'h0, rx_end, rx_both_done, tx_end, tx_both_done}, 32'h0);
    chk("R1 mem_req", {31'h0, mem_req}, 32'h0);
    for (int a = 'h100; a <= 'h124; a += 4) rd_chk("R1 reg", 9'(a), 32'h0);

    // R2 register table walk
    for (int i = 0; i < 8; i++) begin
      wr(VEC[i][72:64], VEC[i][63:32]);
      rd_chk("R2 readback", VEC[i][72:64], VEC[i][31:0]);
    end
    rd_chk("R2 control reads zero", 9'h120, 32'h0);

    // R3 control / status
    wr(9'h120, 32'h0000_0101);
    rd_chk("R3 both enabled", 9'h124, 32'h0000_0101);
    wr(9'h120, 32'h0000_0003);
    rd_chk("R3 rx disable wins", 9'h124, 32'h0000_0100);
    wr(9'h120, 32'h0000_0300);
    rd_chk("R3 tx disable wins", 9'h124, 32'h0000_0000);

    // R13 disabled direction ignores ready
    n_log = 0;
    wr(9'h100, 32'h800); wr(9'h104, 32'd3); wr(9'h114, 32'd0);
    rx_pending = 2;
    idle(10);
    chk("R13 no memory access", 32'(n_log), 32'd0);
    chk("R13 no take", 32'(rx_pending), 32'd2);
    rd_chk("R13 count kept", 9'h104, 32'd3);
    rd_chk("R13 addr kept", 9'h100, 32'h800);
    rx_pending = 0;

    // R4 R5 R7 R10 receive with chaining and grant wait
    size_sel = 2'd0; gnt_dly = 2; n_log = 0; rx_seen = 0; rx_base = 32'h55;
    wr(9'h100, 32'h1000); wr(9'h104, 32'd2);
    wr(9'h110, 32'h2000); wr(9'h114, 32'd1);
    rx_pending = 4;
    wr(9'h120, 32'h1);
    idle(40);
    chk("R10 writes", 32'(n_log), 32'd3);
    chk("R10 we", {31'h0, log_we[0]}, 32'd1);
    chk("R10 data0", log_data[0], 32'h55);
    chk("R4 addr0", log_addr[0], 32'h1000);
    chk("R4 addr1 step1", log_addr[1], 32'h1001);
    chk("R10 data1", log_data[1], 32'h56);
    chk("R5 chained addr", log_addr[2], 32'h2000);
    chk("R5 chained data", log_data[2], 32'h57);
    chk("R6 stopped, one unit left", 32'(rx_pending), 32'd1);
    rd_chk("R4 final addr", 9'h100, 32'h2001);
    rd_chk("R6 count zero", 9'h104, 32'd0);
    rd_chk("R5 queued cleared", 9'h114, 32'd0);
    chk("R7 rx_end", {31'h0, rx_end}, 32'd1);
    chk("R7 rx_both_done", {31'h0, rx_both_done}, 32'd1);

    // R8 flag clear, R9 immediate load
    rx_pending = 0; gnt_dly = 0;
    wr(9'h104, 32'd0);
    chk("R8 flags cleared", {30'h0, rx_end, rx_both_done}, 32'd0);
    wr(9'h110, 32'h3000); wr(9'h114, 32'd5);
    rd_chk("R9 count loaded", 9'h104, 32'd5);
    rd_chk("R9 addr loaded", 9'h100, 32'h3000);
    rd_chk("R9 queued zero", 9'h114, 32'd0);
    wr(9'h120, 32'h2);

    // R11 R4 R7 transmit, word size
    size_sel = 2'd2; n_log = 0; n_tx = 0;
    wr(9'h108, 32'h400); wr(9'h10C, 32'd2); wr(9'h11C, 32'd0);
    tx_ready = 1'b1;
    wr(9'h120, 32'h100);
    idle(20);
    tx_ready = 1'b0;
    chk("R11 loads", 32'(n_tx), 32'd2);
    chk("R11 data0", tx_log[0], mem_val(32'h400));
    chk("R11 data1 step4", tx_log[1], mem_val(32'h404));
    chk("R11 read request", {31'h0, log_we[0]}, 32'd0);
    rd_chk("R4 tx addr", 9'h108, 32'h408);
    rd_chk("R6 tx count", 9'h10C, 32'd0);
    chk("R7 tx flags", {30'h0, tx_end, tx_both_done}, 32'd3);
    wr(9'h10C, 32'd0);
    chk("R8 tx flags cleared", {30'h0, tx_end, tx_both_done}, 32'd0);
    wr(9'h120, 32'h200);

    // R12 receive first, halfword size
    size_sel = 2'd1; n_log = 0; n_tx = 0;
    wr(9'h100, 32'h500); wr(9'h104, 32'd1);
    wr(9'h108, 32'h600); wr(9'h10C, 32'd1);
    tx_ready = 1'b1; rx_pending = 1;
    wr(9'h120, 32'h101);
    idle(20);
    tx_ready = 1'b0;
    chk("R12 count", 32'(n_log), 32'd2);
    chk("R12 rx first", {31'h0, log_we[0]}, 32'd1);
    chk("R12 rx addr", log_addr[0], 32'h500);
    chk("R12 tx second addr", log_addr[1], 32'h600);
    rd_chk("R4 rx step2", 9'h100, 32'h502);
    rd_chk("R4 tx step2", 9'h108, 32'h602);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule